// File: doc/BRIEF.md
# ADC Amplitude Threshold and Gain-Control Monitor

This block sits beside a data converter and turns its sample stream into fast indicators for an external automatic gain control loop. It receives two views of the input: a 3-bit coarse level from the converter's early stage, and the signed 10-bit sample leaving the end of the pipeline, together with a raw overrange flag. The indicators are a coarse "level too high" flag, a fine upper and a fine lower amplitude flag, an overrange flag, a decrease-gain request and an increase-gain request.

The thresholds, the dwell count and the output mode arrive as static configuration inputs. Every amplitude test uses the sample magnitude, so positive and negative excursions are treated the same way. The coarse flag is stretched to a minimum width so that a one-cycle spike is not lost. The increase-gain request asks for more gain only after the signal has stayed quiet for a programmable number of cycles. A mode field routes either the raw coarse level, a delayed slice of it, or a mix of indicators onto a 4-bit fast-detect output.

Top module: `adc_gain_monitor`

## Requirements
- R1: Fine comparisons use the magnitude of the two's complement sample; a sample and its negation give the same flags, and the most negative code -512 counts as magnitude 511.
- R2: `over_fine_o` is 1 one clock edge after a sample whose magnitude is strictly greater than `fine_hi_i` (13 bits, zero-extended magnitude).
- R3: `under_fine_o` is 1 one clock edge after a sample whose magnitude is strictly less than `fine_lo_i`.
- R4: The coarse comparison is true when `coarse_lvl_i` is strictly greater than `coarse_thr_i`; `over_coarse_o` rises two clock edges after such a level is presented.
- R5: Once `over_coarse_o` rises it stays high for at least two cycles, and it stays high for as long as the comparison keeps holding; it then falls with no extra tail.
- R6: `gain_down_o` is the coarse comparison with the same two-edge latency but without the stretch.
- R7: `gain_up_o` is 1 only while `under_fine_o` is 1 and the current run of consecutive below-threshold samples has reached `dwell_i` (count includes the current sample); any sample at or above `fine_lo_i` restarts the run at zero. Dwell 1 makes it rise together with `under_fine_o`.
- R8: `clip_o` equals `ovr_raw_i` as it was 12 clock edges earlier.
- R9: Mode 000 drives `fast_o` = {0, coarse level delayed by 2 edges}.
- R10: Mode 001 drives `fast_o` = {coarse level delayed by 6 edges, `clip_o`}; mode 010 drives {bits 2:1 of that delayed level, `over_coarse_o`, `clip_o`}; mode 011 drives {bits 2:1 of that delayed level, `over_fine_o`, `clip_o`} (bit 3 leftmost).
- R11: Mode 100 drives `fast_o` = {`clip_o`, `over_coarse_o`, `over_fine_o`, `under_fine_o`}; mode 101 drives {`clip_o`, `over_fine_o`, `gain_up_o`, `gain_down_o`}.
- R12: Modes 110 and 111 drive `fast_o` to 0000.
- R13: While `rst_n` is low every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coarse_lvl_i | input | 3 | Early-stage coarse level |
| sample_i | input | 10 | Two's complement sample at pipeline end |
| ovr_raw_i | input | 1 | Raw overrange flag at the input |
| coarse_thr_i | input | 3 | Coarse upper threshold |
| fine_hi_i | input | 13 | Fine upper magnitude threshold |
| fine_lo_i | input | 13 | Fine lower magnitude threshold |
| dwell_i | input | 16 | Quiet cycles required before increase-gain |
| fd_mode_i | input | 3 | Fast-detect output mode |
| fast_o | output | 4 | Fast-detect output bus |
| over_coarse_o | output | 1 | Stretched coarse upper indicator |
| over_fine_o | output | 1 | Fine upper indicator |
| under_fine_o | output | 1 | Fine lower indicator |
| clip_o | output | 1 | Delayed overrange indicator |
| gain_down_o | output | 1 | Decrease-gain request |
| gain_up_o | output | 1 | Increase-gain request |

## Verification
Full-range random samples with random coarse levels are run in every mode, which exercises the output multiplexer together with both level delay lines and separates modes that share the same indicators. Directed samples at -512 against upper thresholds 510 and 511 tell a saturating magnitude from a wrapping or sign-blind one, and mixed-sign samples show that the sign never matters. Single-cycle coarse spikes next to long coarse bursts separate a minimum-width stretch from a stretch that adds a tail. Runs of quiet samples of various lengths, broken by one loud sample, try dwell values 1, 7 and 300 and show whether the run restarts and when the increase-gain request first appears.

// File: rtl/agm_pkg.sv
package agm_pkg;
  localparam int LVL_W = 3;
  localparam int FD_W  = 4;

  typedef enum logic [2:0] {
    FD_RAW     = 3'b000,
    FD_SLOW3   = 3'b001,
    FD_SLOW2_C = 3'b010,
    FD_SLOW2_F = 3'b011,
    FD_GAIN_A  = 3'b100,
    FD_GAIN_B  = 3'b101
  } fd_mode_e;

  typedef struct packed {
    logic clip;
    logic c_hi;
    logic f_hi;
    logic f_lo;
    logic g_dn;
    logic g_up;
  } agm_flags_t;

  function automatic logic [FD_W-1:0] fd_route(input logic [2:0] mode,
                                                input agm_flags_t fl,
                                                input logic [LVL_W-1:0] lvl_fast,
                                                input logic [LVL_W-1:0] lvl_slow);
    logic [FD_W-1:0] r;
    case (mode)
      FD_RAW:     r = {1'b0, lvl_fast};
      FD_SLOW3:   r = {lvl_slow, fl.clip};
      FD_SLOW2_C: r = {lvl_slow[2:1], fl.c_hi, fl.clip};
      FD_SLOW2_F: r = {lvl_slow[2:1], fl.f_hi, fl.clip};
      FD_GAIN_A:  r = {fl.clip, fl.c_hi, fl.f_hi, fl.f_lo};
      FD_GAIN_B:  r = {fl.clip, fl.f_hi, fl.g_up, fl.g_dn};
      default:    r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/agm_delay.sv
module agm_delay #(
  parameter int W     = 1,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= d_i;
      end
      assert_head_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stg_q[0] == $past(d_i));
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= '0;
        else        stg_q[i] <= stg_q[i-1];
      end
      assert_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stg_q[i] == $past(stg_q[i-1]));
    end
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/agm_coarse.sv
module agm_coarse #(
  parameter int LVL_W    = 3,
  parameter int MIN_HOLD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] thr_i,
  output logic             c_hi_o,
  output logic             g_dn_o
);
  localparam int AGE_W = $clog2(MIN_HOLD + 1);

  logic [LVL_W-1:0] lvl_q;
  logic [AGE_W-1:0] age_q;
  logic             cmp_w;
  logic             keep_w;

  // event wires for the assertions
  assign cmp_w  = lvl_q > thr_i;
  assign keep_w = c_hi_o && (age_q < AGE_W'(MIN_HOLD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      age_q  <= '0;
      c_hi_o <= 1'b0;
      g_dn_o <= 1'b0;
    end else begin
      lvl_q  <= lvl_i;
      g_dn_o <= cmp_w;
      if (cmp_w || keep_w) begin
        c_hi_o <= 1'b1;
        if (!c_hi_o)                         age_q <= AGE_W'(1);
        else if (age_q != AGE_W'(MIN_HOLD))  age_q <= age_q + 1'b1;
      end else begin
        c_hi_o <= 1'b0;
        age_q  <= '0;
      end
    end
  end

  assert_cmp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_w |=> c_hi_o);
  assert_stretch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c_hi_o) |=> c_hi_o);
  assert_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    g_dn_o |-> c_hi_o);
endmodule

// File: rtl/agm_fine.sv
module agm_fine #(
  parameter int DW = 10,
  parameter int TW = 13,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] sample_i,
  input  logic [TW-1:0] hi_i,
  input  logic [TW-1:0] lo_i,
  input  logic [CW-1:0] dwell_i,
  output logic          f_hi_o,
  output logic          f_lo_o,
  output logic          g_up_o
);
  function automatic logic [DW-2:0] mag_sat(input logic [DW-1:0] s);
    logic [DW-1:0] n;
    n = ~s + 1'b1;
    if (!s[DW-1])     return s[DW-2:0];
    else if (n[DW-1]) return '1;
    else              return n[DW-2:0];
  endfunction

  logic [TW-1:0] mag_w;
  logic          above_w;
  logic          below_w;
  logic [CW-1:0] run_q;
  logic [CW:0]   run_nx;

  assign mag_w   = TW'(mag_sat(sample_i));
  assign above_w = mag_w > hi_i;
  assign below_w = mag_w < lo_i;
  assign run_nx  = {1'b0, run_q} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_hi_o <= 1'b0;
      f_lo_o <= 1'b0;
      g_up_o <= 1'b0;
      run_q  <= '0;
    end else begin
      f_hi_o <= above_w;
      f_lo_o <= below_w;
      if (below_w) begin
        run_q  <= run_nx[CW] ? run_q : run_nx[CW-1:0];
        g_up_o <= run_nx >= {1'b0, dwell_i};
      end else begin
        run_q  <= '0;
        g_up_o <= 1'b0;
      end
    end
  end

  always_comb begin
    if (rst_n && sample_i != {1'b1, {(DW-1){1'b0}}})
      assert_sym_R1: assert (mag_sat(sample_i) == mag_sat(~sample_i + 1'b1));
  end

  assert_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    g_up_o |-> f_lo_o);
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !below_w |=> !g_up_o);
endmodule

// File: rtl/adc_gain_monitor.sv
module adc_gain_monitor
  import agm_pkg::*;
#(
  parameter int DW       = 10,
  parameter int TW       = 13,
  parameter int CW       = 16,
  parameter int FAST_LAT = 2,
  parameter int SLOW_LAT = 6,
  parameter int OVR_LAT  = 12,
  parameter int MIN_HOLD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] coarse_lvl_i,
  input  logic [DW-1:0]    sample_i,
  input  logic             ovr_raw_i,
  input  logic [LVL_W-1:0] coarse_thr_i,
  input  logic [TW-1:0]    fine_hi_i,
  input  logic [TW-1:0]    fine_lo_i,
  input  logic [CW-1:0]    dwell_i,
  input  logic [2:0]       fd_mode_i,
  output logic [FD_W-1:0]  fast_o,
  output logic             over_coarse_o,
  output logic             over_fine_o,
  output logic             under_fine_o,
  output logic             clip_o,
  output logic             gain_down_o,
  output logic             gain_up_o
);
  localparam int EXTRA_LAT = SLOW_LAT - FAST_LAT;

  logic [LVL_W-1:0] lvl_fast_w;
  logic [LVL_W-1:0] lvl_slow_w;
  agm_flags_t       flags_w;

  agm_delay #(.W(LVL_W), .DEPTH(FAST_LAT)) u_lvl_fast (
    .clk(clk), .rst_n(rst_n), .d_i(coarse_lvl_i), .q_o(lvl_fast_w));

  agm_delay #(.W(LVL_W), .DEPTH(EXTRA_LAT)) u_lvl_slow (
    .clk(clk), .rst_n(rst_n), .d_i(lvl_fast_w), .q_o(lvl_slow_w));

  agm_delay #(.W(1), .DEPTH(OVR_LAT)) u_clip (
    .clk(clk), .rst_n(rst_n), .d_i(ovr_raw_i), .q_o(clip_o));

  agm_coarse #(.LVL_W(LVL_W), .MIN_HOLD(MIN_HOLD)) u_coarse (
    .clk(clk), .rst_n(rst_n), .lvl_i(coarse_lvl_i), .thr_i(coarse_thr_i),
    .c_hi_o(over_coarse_o), .g_dn_o(gain_down_o));

  agm_fine #(.DW(DW), .TW(TW), .CW(CW)) u_fine (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .hi_i(fine_hi_i),
    .lo_i(fine_lo_i), .dwell_i(dwell_i), .f_hi_o(over_fine_o),
    .f_lo_o(under_fine_o), .g_up_o(gain_up_o));

  assign flags_w = '{clip: clip_o, c_hi: over_coarse_o, f_hi: over_fine_o,
                     f_lo: under_fine_o, g_dn: gain_down_o, g_up: gain_up_o};
  assign fast_o  = fd_route(fd_mode_i, flags_w, lvl_fast_w, lvl_slow_w);

  assert_undef_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fd_mode_i == 3'b110 || fd_mode_i == 3'b111) |-> fast_o == '0);
  assert_raw_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fd_mode_i == 3'b000) |-> !fast_o[FD_W-1]);
endmodule

// File: tb/adc_gain_monitor_bench.sv
`timescale 1ns/1ps
module adc_gain_monitor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  lvl = '0;
  logic signed [9:0] smp = '0;
  logic        ovr_raw = 1'b0;
  logic [2:0]  thr = 3'd4;
  logic [12:0] hi = 13'd400;
  logic [12:0] lo = 13'd40;
  logic [15:0] dwell = 16'd5;
  logic [2:0]  mode = '0;
  logic [3:0]  fast;
  logic        o_chi, o_fhi, o_flo, o_clip, o_dn, o_up;

  always #2 clk = ~clk;

  adc_gain_monitor u_adc_gain_monitor (
    .clk(clk), .rst_n(rst_n), .coarse_lvl_i(lvl), .sample_i(smp),
    .ovr_raw_i(ovr_raw), .coarse_thr_i(thr), .fine_hi_i(hi), .fine_lo_i(lo),
    .dwell_i(dwell), .fd_mode_i(mode), .fast_o(fast),
    .over_coarse_o(o_chi), .over_fine_o(o_fhi), .under_fine_o(o_flo),
    .clip_o(o_clip), .gain_down_o(o_dn), .gain_up_o(o_up));

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // behavioural reference: histories and run counts
  int lvl_h[6];
  int ovr_h[12];
  int e_chi, e_dn, e_fhi, e_flo, e_up;
  int chi_run, quiet_run;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      foreach (lvl_h[i]) lvl_h[i] = 0;
      foreach (ovr_h[i]) ovr_h[i] = 0;
      e_chi = 0; e_dn = 0; e_fhi = 0; e_flo = 0; e_up = 0;
      chi_run = 0; quiet_run = 0;
    end else begin
      int above;
      int m;
      above = (lvl_h[0] > int'(thr)) ? 1 : 0;
      e_chi = (above == 1 || (e_chi == 1 && chi_run < 2)) ? 1 : 0;
      chi_run = e_chi ? chi_run + 1 : 0;
      e_dn = above;
      m = int'(smp);
      if (m < 0) m = -m;
      if (m > 511) m = 511;
      e_fhi = (m > int'(hi)) ? 1 : 0;
      e_flo = (m < int'(lo)) ? 1 : 0;
      quiet_run = e_flo ? quiet_run + 1 : 0;
      e_up = (e_flo == 1 && quiet_run >= int'(dwell)) ? 1 : 0;
      for (int i = 11; i > 0; i--) ovr_h[i] = ovr_h[i-1];
      ovr_h[0] = int'(ovr_raw);
      for (int i = 5; i > 0; i--) lvl_h[i] = lvl_h[i-1];
      lvl_h[0] = int'(lvl);
    end
  end

  function automatic int exp_fast(int md);
    case (md)
      0: return lvl_h[1];
      1: return lvl_h[5] * 2 + ovr_h[11];
      2: return (lvl_h[5] / 2) * 4 + e_chi * 2 + ovr_h[11];
      3: return (lvl_h[5] / 2) * 4 + e_fhi * 2 + ovr_h[11];
      4: return ovr_h[11] * 8 + e_chi * 4 + e_fhi * 2 + e_flo;
      5: return ovr_h[11] * 8 + e_fhi * 4 + e_up * 2 + e_dn;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic tick();
    string ft;
    @(negedge clk);
    if (!rst_n) begin
      chk("R13 reset outputs", {fast, o_chi, o_fhi, o_flo, o_clip, o_dn, o_up}, 0);
    end else begin
      chk("R4 R5 over_coarse", o_chi, e_chi);
      chk("R1 R2 over_fine", o_fhi, e_fhi);
      chk("R1 R3 under_fine", o_flo, e_flo);
      chk("R8 clip", o_clip, ovr_h[11]);
      chk("R6 gain_down", o_dn, e_dn);
      chk("R7 gain_up", o_up, e_up);
      ft = (mode == 0) ? "R9 fast" : (mode <= 3) ? "R10 fast" :
           (mode <= 5) ? "R11 fast" : "R12 fast";
      chk(ft, int'(fast), exp_fast(int'(mode)));
    end
  endtask

  task automatic random_run(int n, int max_mag);
    for (int k = 0; k < n; k++) begin
      int v;
      v = int'($urandom_range(2 * max_mag)) - max_mag;
      smp = 10'(v);
      lvl = 3'($urandom_range(7));
      ovr_raw = ($urandom_range(9) == 0);
      tick();
    end
  endtask

  task automatic quiet_burst(int len, int base);
    for (int k = 0; k < len; k++) begin
      smp = 10'((k % 2 == 0) ? base : -base);
      tick();
    end
    smp = 10'(-200);
    tick();
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d actual running expected done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(13));
    // R13: reset state
    for (int k = 0; k < 4; k++) tick();
    rst_n = 1'b1;
    tick();

    // R9 R10 R11 R12: every mode under random full-range traffic
    for (int md = 0; md < 8; md++) begin
      mode = 3'(md);
      thr  = 3'(md % 7);
      hi   = 13'(100 + 50 * md);
      lo   = 13'(20 + 30 * md);
      random_run(150, 512);
    end

    // R1 R2: most negative code saturates to 511
    mode = 3'b100; lo = 13'd3; ovr_raw = 1'b0; lvl = '0;
    hi = 13'd510;
    smp = 10'sh200; tick(); tick();
    smp = 10'sd510; tick(); tick();
    hi = 13'd511;
    smp = 10'sh200; tick(); tick();
    smp = -10'sd511; tick(); tick();
    hi = 13'd8191; smp = 10'sd511; tick(); tick();

    // R4 R5 R6: single-cycle spikes and long bursts
    thr = 3'd3; smp = 10'sd100;
    for (int rep = 0; rep < 3; rep++) begin
      lvl = 3'd4; tick();
      lvl = 3'd0; tick(); tick(); tick(); tick();
      lvl = 3'd7; tick(); tick(); tick(); tick(); tick();
      lvl = 3'd3; tick(); tick(); tick(); tick();
      lvl = 3'd5; tick(); tick();
      lvl = 3'd1; tick(); tick(); tick(); tick();
    end

    // R7: dwell behaviour, restart on a loud sample
    mode = 3'b101; lo = 13'd20; hi = 13'd300;
    dwell = 16'd7;
    quiet_burst(3, 5); quiet_burst(10, 19); quiet_burst(6, 0); quiet_burst(7, 19);
    smp = 10'sd20; tick(); quiet_burst(8, 10);
    dwell = 16'd1;
    quiet_burst(1, 4); quiet_burst(5, 12);
    dwell = 16'd300;
    quiet_burst(299, 7); quiet_burst(320, 7);

    // mixed random traffic with quiet bias, gain modes
    mode = 3'b101; dwell = 16'd4; lo = 13'd60; thr = 3'd5;
    random_run(300, 80);
    mode = 3'b010;
    random_run(200, 512);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule